// File: doc/BRIEF.md
# DDR3 Device Command Decoder

This block sits behind the command and address pins of a DDR3 memory device. On every rising clock edge it captures clock enable, the four active-low command strobes (chip select, row strobe, column strobe, write enable), the bank address and the address bus. In the following cycle it turns the captured pins into one decoded command pulse. Each pulse comes with the fields that belong to its command. An activate carries a bank and a row. A read or write carries a bank, a column, an auto-precharge flag and a burst-chop flag. A precharge carries a bank and a single-or-all flag. A refresh carries no field. A mode-register load carries a register selector and an opcode.

The meaning of the address bus depends on the command. The row uses the full bus. The column takes its bits around A10, and the chosen bits depend on the data width parameter (x4 or x8). A10 is the auto-precharge flag on reads and writes and the all-banks flag on precharge. A12 gives the per-access burst chop, but only when the burst mode last written to mode register 0 allows it. The decoder keeps that burst mode itself by watching its own mode-register loads. The memory array, timing checks and the electrical behaviour of the pins are handled by other blocks.

Top module: `ddr3_cmd_decode`

## Requirements
- R1: A command present on the pins at rising edge k gives its decoded pulse high for exactly the clock cycle that follows rising edge k+1, with its fields valid in that cycle. At most one of the six pulses is high at any time.
- R2: When chip select (cs_n) is high at the sampling edge, no pulse is produced, whatever the other pins are.
- R3: When cke is low at the sampling edge, no pulse is produced, whatever the other pins are.
- R4: With cke high, the pattern {cs_n,ras_n,cas_n,we_n} decodes as follows: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode load. The patterns 0111 (no-operation) and 0110 produce no pulse.
- R5: An activate reports act_bank = BA[2:0] and act_row = A[14:0].
- R6: A read or write reports col_bank = BA[2:0] and col_ap = A10. With DQ_W = 4, col_addr = {A11, A[9:0]} (11 bits). With DQ_W = 8, col_addr = A[9:0] (10 bits).
- R7: The burst mode is held in 2 bits and is loaded from opcode bits [1:0] of a mode load with BA[1:0] = 0. Loads to other registers leave it unchanged. Reset sets it to 00. In mode 00 (fixed 8) and mode 11, col_chop = 0. In mode 01 (on the fly), col_chop = NOT A12. In mode 10 (fixed 4), col_chop = 1.
- R8: A precharge reports pre_all = A10 and pre_bank = BA[2:0]. pre_all = 0 means the one bank named by pre_bank is precharged, and pre_all = 1 means all banks are.
- R9: A mode load reports mrs_sel = BA[1:0] and mrs_op = A[14:0].
- R10: A refresh raises ref_vld alone.
- R11: While rst_n is low, and until the first command is sampled after its synchronous release, all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge samples pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address pins |
| addr | input | ADDR_W | Address pins |
| act_vld | output | 1 | Activate pulse |
| act_bank | output | BA_W | Activate bank |
| act_row | output | ADDR_W | Activate row |
| rd_vld | output | 1 | Read pulse |
| wr_vld | output | 1 | Write pulse |
| col_bank | output | BA_W | Read/write bank |
| col_addr | output | 11 (x4) or 10 (x8) | Read/write starting column |
| col_ap | output | 1 | Auto-precharge requested |
| col_chop | output | 1 | Burst chopped to 4 |
| pre_vld | output | 1 | Precharge pulse |
| pre_all | output | 1 | Precharge targets all banks |
| pre_bank | output | BA_W | Precharge bank when not all |
| ref_vld | output | 1 | Refresh pulse |
| mrs_vld | output | 1 | Mode-register load pulse |
| mrs_sel | output | 2 | Mode register selected |
| mrs_op | output | ADDR_W | Mode-register opcode |

## Verification
The assertions check on every cycle that the pulses are mutually exclusive. They also check that a cycle with chip select high or clock enable low yields no pulse, that each pulse follows the strobe pattern captured one cycle earlier, and that the row, the precharge scope and the mode opcode match the captured address. Only the bench scenarios can show the column bit selection for both widths, with an x4 and an x8 instance side by side. The same holds for the burst-chop result after a series of mode loads, the fact that loads to other registers leave the burst mode alone, and the silence of the no-operation pattern and the unused pattern.

// File: rtl/ddrcd_pkg.sv
package ddrcd_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_REF  = 3'd5,
    OP_MRS  = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    BLM_FIX8 = 2'b00,
    BLM_OTF  = 2'b01,
    BLM_FIX4 = 2'b10,
    BLM_RSVD = 2'b11
  } blmode_e;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/ddrcd_in_capture.sv
module ddrcd_in_capture
  import ddrcd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl_d,
  input  logic [BA_W-1:0]   ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  output ctl_t              ctl_q,
  output logic [BA_W-1:0]   ba_q,
  output logic [ADDR_W-1:0] addr_q
);

  ctl_t              ctl_nxt;
  logic [BA_W-1:0]   ba_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  always_comb begin
    ctl_nxt  = ctl_d;
    ba_nxt   = ba_d;
    addr_nxt = addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_IDLE;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      ctl_q  <= ctl_nxt;
      ba_q   <= ba_nxt;
      addr_q <= addr_nxt;
    end
  end

endmodule

// File: rtl/ddrcd_classify.sv
module ddrcd_classify
  import ddrcd_pkg::*;
(
  input  ctl_t ctl,
  output op_e  op
);

  always_comb begin
    op = OP_NONE;
    if (ctl.cke && !ctl.cs_n) begin
      unique case ({ctl.ras_n, ctl.cas_n, ctl.we_n})
        3'b011:  op = OP_ACT;
        3'b101:  op = OP_RD;
        3'b100:  op = OP_WR;
        3'b010:  op = OP_PRE;
        3'b001:  op = OP_REF;
        3'b000:  op = OP_MRS;
        default: op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/ddrcd_col_extract.sv
module ddrcd_col_extract #(
  parameter int DQ_W  = 4,
  parameter int COL_W = (DQ_W == 4) ? 11 : 10
) (
  input  logic [11:0]      addr_lo,
  output logic [COL_W-1:0] col,
  output logic             ap
);

  assign ap = addr_lo[10];

  generate
    if (DQ_W == 4) begin : g_x4
      assign col = {addr_lo[11], addr_lo[9:0]};
    end else begin : g_x8
      logic unused_a11;
      assign unused_a11 = addr_lo[11];
      assign col = addr_lo[9:0];
    end
  endgenerate

endmodule

// File: rtl/ddrcd_burst_mode.sv
module ddrcd_burst_mode
  import ddrcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic [1:0] op_bl,
  input  logic       a12,
  output logic       chop
);

  blmode_e mode_q, mode_nxt;

  always_comb begin
    mode_nxt = mode_q;
    if (upd) mode_nxt = blmode_e'(op_bl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= BLM_FIX8;
    else if (upd) mode_q <= mode_nxt;
  end

  always_comb begin
    unique case (mode_q)
      BLM_OTF:  chop = !a12;
      BLM_FIX4: chop = 1'b1;
      default:  chop = 1'b0;
    endcase
  end

  p_mode_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(mode_q));

endmodule

// File: rtl/ddr3_cmd_decode.sv
module ddr3_cmd_decode
  import ddrcd_pkg::*;
#(
  parameter int DQ_W   = 4,
  parameter int ADDR_W = 15,
  parameter int BA_W   = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cke,
  input  logic                                 cs_n,
  input  logic                                 ras_n,
  input  logic                                 cas_n,
  input  logic                                 we_n,
  input  logic [BA_W-1:0]                      ba,
  input  logic [ADDR_W-1:0]                    addr,
  output logic                                 act_vld,
  output logic [BA_W-1:0]                      act_bank,
  output logic [ADDR_W-1:0]                    act_row,
  output logic                                 rd_vld,
  output logic                                 wr_vld,
  output logic [BA_W-1:0]                      col_bank,
  output logic [((DQ_W == 4) ? 11 : 10)-1:0]   col_addr,
  output logic                                 col_ap,
  output logic                                 col_chop,
  output logic                                 pre_vld,
  output logic                                 pre_all,
  output logic [BA_W-1:0]                      pre_bank,
  output logic                                 ref_vld,
  output logic                                 mrs_vld,
  output logic [1:0]                           mrs_sel,
  output logic [ADDR_W-1:0]                    mrs_op
);

  localparam int COL_W = (DQ_W == 4) ? 11 : 10;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  ctl_t              pin_ctl, cap_ctl;
  logic [BA_W-1:0]   cap_ba;
  logic [ADDR_W-1:0] cap_addr;

  assign pin_ctl = '{cke: cke, cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};

  ddrcd_in_capture #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_s),
    .ctl_d  (pin_ctl),
    .ba_d   (ba),
    .addr_d (addr),
    .ctl_q  (cap_ctl),
    .ba_q   (cap_ba),
    .addr_q (cap_addr)
  );

  op_e op;
  ddrcd_classify u_cls (
    .ctl (cap_ctl),
    .op  (op)
  );

  logic [COL_W-1:0] col_nxt;
  logic             ap_nxt;
  ddrcd_col_extract #(.DQ_W(DQ_W), .COL_W(COL_W)) u_col (
    .addr_lo (cap_addr[11:0]),
    .col     (col_nxt),
    .ap      (ap_nxt)
  );

  logic mr0_upd, chop_nxt;
  assign mr0_upd = (op == OP_MRS) && (cap_ba[1:0] == 2'b00);

  ddrcd_burst_mode u_blm (
    .clk   (clk),
    .rst_n (rst_s),
    .upd   (mr0_upd),
    .op_bl (cap_addr[1:0]),
    .a12   (cap_addr[12]),
    .chop  (chop_nxt)
  );

  // next-state
  logic act_nxt, rd_nxt, wr_nxt, pre_nxt, ref_nxt, mrs_nxt;
  logic act_en, col_en, pre_en, mrs_en;

  always_comb begin
    act_nxt = (op == OP_ACT);
    rd_nxt  = (op == OP_RD);
    wr_nxt  = (op == OP_WR);
    pre_nxt = (op == OP_PRE);
    ref_nxt = (op == OP_REF);
    mrs_nxt = (op == OP_MRS);
    act_en  = act_nxt;
    col_en  = rd_nxt | wr_nxt;
    pre_en  = pre_nxt;
    mrs_en  = mrs_nxt;
  end

  // pulse registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      act_vld <= 1'b0;
      rd_vld  <= 1'b0;
      wr_vld  <= 1'b0;
      pre_vld <= 1'b0;
      ref_vld <= 1'b0;
      mrs_vld <= 1'b0;
    end else begin
      act_vld <= act_nxt;
      rd_vld  <= rd_nxt;
      wr_vld  <= wr_nxt;
      pre_vld <= pre_nxt;
      ref_vld <= ref_nxt;
      mrs_vld <= mrs_nxt;
    end
  end

  // field registers, loaded only with their command
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      act_bank <= '0;
      act_row  <= '0;
    end else if (act_en) begin
      act_bank <= cap_ba;
      act_row  <= cap_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      col_bank <= '0;
      col_addr <= '0;
      col_ap   <= 1'b0;
      col_chop <= 1'b0;
    end else if (col_en) begin
      col_bank <= cap_ba;
      col_addr <= col_nxt;
      col_ap   <= ap_nxt;
      col_chop <= chop_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pre_all  <= 1'b0;
      pre_bank <= '0;
    end else if (pre_en) begin
      pre_all  <= cap_addr[10];
      pre_bank <= cap_ba;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mrs_sel <= '0;
      mrs_op  <= '0;
    end else if (mrs_en) begin
      mrs_sel <= cap_ba[1:0];
      mrs_op  <= cap_addr;
    end
  end

  logic any_pulse;
  assign any_pulse = act_vld | rd_vld | wr_vld | pre_vld | ref_vld | mrs_vld;

  p_one_pulse_r1: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({act_vld, rd_vld, wr_vld, pre_vld, ref_vld, mrs_vld}));

  p_cs_mask_r2: assert property (@(posedge clk) disable iff (!rst_s)
    cap_ctl.cs_n |=> !any_pulse);

  p_cke_gate_r3: assert property (@(posedge clk) disable iff (!rst_s)
    !cap_ctl.cke |=> !any_pulse);

  p_rd_code_r4: assert property (@(posedge clk) disable iff (!rst_s)
    rd_vld |-> ($past(cap_ctl.ras_n) && !$past(cap_ctl.cas_n) && $past(cap_ctl.we_n)));

  p_act_fields_r5: assert property (@(posedge clk) disable iff (!rst_s)
    act_vld |-> (act_row == $past(cap_addr) && act_bank == $past(cap_ba)));

  p_pre_scope_r8: assert property (@(posedge clk) disable iff (!rst_s)
    pre_vld |-> (pre_all == $past(cap_addr[10]) && pre_bank == $past(cap_ba)));

  p_mrs_op_r9: assert property (@(posedge clk) disable iff (!rst_s)
    mrs_vld |-> (mrs_op == $past(cap_addr) && mrs_sel == $past(cap_ba[1:0])));

endmodule

// File: tb/test_ddr3_cmd_decode.sv
`timescale 1ns/1ps
module test_ddr3_cmd_decode;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [2:0]  ba;
  logic [14:0] addr;

  logic        act_vld, rd_vld, wr_vld, pre_vld, ref_vld, mrs_vld;
  logic [2:0]  act_bank, col_bank, pre_bank;
  logic [14:0] act_row, mrs_op;
  logic [10:0] col_addr;
  logic        col_ap, col_chop, pre_all;
  logic [1:0]  mrs_sel;

  logic        x8_act, x8_rd, x8_wr, x8_pre, x8_ref, x8_mrs;
  logic [2:0]  x8_act_bank, x8_col_bank, x8_pre_bank;
  logic [14:0] x8_act_row, x8_mrs_op;
  logic [9:0]  x8_col_addr;
  logic        x8_ap, x8_chop, x8_pre_all;
  logic [1:0]  x8_mrs_sel;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ddr3_cmd_decode #(.DQ_W(4)) i_ddr3_cmd_decode (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr),
    .act_vld(act_vld), .act_bank(act_bank), .act_row(act_row),
    .rd_vld(rd_vld), .wr_vld(wr_vld), .col_bank(col_bank), .col_addr(col_addr),
    .col_ap(col_ap), .col_chop(col_chop),
    .pre_vld(pre_vld), .pre_all(pre_all), .pre_bank(pre_bank),
    .ref_vld(ref_vld), .mrs_vld(mrs_vld), .mrs_sel(mrs_sel), .mrs_op(mrs_op)
  );

  ddr3_cmd_decode #(.DQ_W(8)) i_ddr3_cmd_decode_x8 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr),
    .act_vld(x8_act), .act_bank(x8_act_bank), .act_row(x8_act_row),
    .rd_vld(x8_rd), .wr_vld(x8_wr), .col_bank(x8_col_bank), .col_addr(x8_col_addr),
    .col_ap(x8_ap), .col_chop(x8_chop),
    .pre_vld(x8_pre), .pre_all(x8_pre_all), .pre_bank(x8_pre_bank),
    .ref_vld(x8_ref), .mrs_vld(x8_mrs), .mrs_sel(x8_mrs_sel), .mrs_op(x8_mrs_op)
  );

  // pulse vector order: act rd wr pre ref mrs
  logic [5:0] pv;
  assign pv = {act_vld, rd_vld, wr_vld, pre_vld, ref_vld, mrs_vld};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic put(input logic k, input logic [3:0] code, input logic [2:0] b, input logic [14:0] a);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = code;
    ba = b;
    addr = a;
  endtask

  // drive one command, follow with a no-operation, stop where the pulse shows
  task automatic issue(input logic k, input logic [3:0] code, input logic [2:0] b, input logic [14:0] a);
    put(k, code, b, a);
    @(negedge clk);
    put(1'b1, 4'b0111, 3'd0, 15'd0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    put(1'b1, 4'b0011, 3'd5, 15'h1234);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 pulses in reset", {26'd0, pv}, 32'd0);
    put(1'b1, 4'b1111, 3'd0, 15'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 pulses after release", {26'd0, pv}, 32'd0);
  endtask

  task automatic t_activate;
    issue(1'b1, 4'b0011, 3'd6, 15'h5a3c);
    chk("R4 activate pulse", {26'd0, pv}, 32'b100000);
    chk("R5 act_row", {17'd0, act_row}, 32'h5a3c);
    chk("R5 act_bank", {29'd0, act_bank}, 32'd6);
    chk("R5 x8 act_row", {17'd0, x8_act_row}, 32'h5a3c);
    @(negedge clk);
    chk("R1 single cycle pulse", {26'd0, pv}, 32'd0);
  endtask

  task automatic t_read_write;
    // A11=1, A10=1, A9:0 = 0x2a5
    issue(1'b1, 4'b0101, 3'd3, 15'h0ea5);
    chk("R4 read pulse", {26'd0, pv}, 32'b010000);
    chk("R6 x4 col", {21'd0, col_addr}, {21'd0, 1'b1, 10'h2a5});
    chk("R6 x8 col", {22'd0, x8_col_addr}, 32'h2a5);
    chk("R6 ap set", {31'd0, col_ap}, 32'd1);
    chk("R6 col_bank", {29'd0, col_bank}, 32'd3);
    issue(1'b1, 4'b0100, 3'd1, 15'h0133);
    chk("R4 write pulse", {26'd0, pv}, 32'b001000);
    chk("R6 x4 col A11 low", {21'd0, col_addr}, 32'h133);
    chk("R6 ap clear", {31'd0, col_ap}, 32'd0);
    chk("R6 x8 write", {31'd0, x8_wr}, 32'd1);
  endtask

  task automatic t_precharge;
    issue(1'b1, 4'b0010, 3'd4, 15'h0000);
    chk("R4 precharge pulse", {26'd0, pv}, 32'b000100);
    chk("R8 single bank", {31'd0, pre_all}, 32'd0);
    chk("R8 bank", {29'd0, pre_bank}, 32'd4);
    issue(1'b1, 4'b0010, 3'd2, 15'h0400);
    chk("R8 all banks", {31'd0, pre_all}, 32'd1);
  endtask

  task automatic t_refresh;
    issue(1'b1, 4'b0001, 3'd0, 15'd0);
    chk("R10 refresh alone", {26'd0, pv}, 32'b000010);
  endtask

  task automatic t_mode_load;
    issue(1'b1, 4'b0000, 3'd2, 15'h4d21);
    chk("R9 mode pulse", {26'd0, pv}, 32'b000001);
    chk("R9 sel", {30'd0, mrs_sel}, 32'd2);
    chk("R9 opcode", {17'd0, mrs_op}, 32'h4d21);
  endtask

  task automatic t_burst_chop;
    issue(1'b1, 4'b0101, 3'd0, 15'h0000);
    chk("R7 reset mode no chop", {31'd0, col_chop}, 32'd0);
    issue(1'b1, 4'b0000, 3'd0, 15'h0001);
    issue(1'b1, 4'b0101, 3'd0, 15'h0000);
    chk("R7 otf A12 low chops", {31'd0, col_chop}, 32'd1);
    chk("R7 x8 otf chop", {31'd0, x8_chop}, 32'd1);
    issue(1'b1, 4'b0100, 3'd0, 15'h1000);
    chk("R7 otf A12 high no chop", {31'd0, col_chop}, 32'd0);
    issue(1'b1, 4'b0000, 3'd0, 15'h0002);
    issue(1'b1, 4'b0101, 3'd0, 15'h1000);
    chk("R7 fixed4 chops", {31'd0, col_chop}, 32'd1);
    issue(1'b1, 4'b0000, 3'd0, 15'h0000);
    issue(1'b1, 4'b0000, 3'd1, 15'h0001);
    issue(1'b1, 4'b0101, 3'd0, 15'h0000);
    chk("R7 other register leaves mode", {31'd0, col_chop}, 32'd0);
  endtask

  task automatic t_masking;
    issue(1'b1, 4'b1101, 3'd0, 15'd0);
    chk("R2 cs high masks read", {26'd0, pv}, 32'd0);
    issue(1'b1, 4'b1000, 3'd0, 15'd0);
    chk("R2 cs high masks mode load", {26'd0, pv}, 32'd0);
    issue(1'b1, 4'b0111, 3'd0, 15'd0);
    chk("R4 nop silent", {26'd0, pv}, 32'd0);
    issue(1'b1, 4'b0110, 3'd0, 15'd0);
    chk("R4 unused code silent", {26'd0, pv}, 32'd0);
  endtask

  task automatic t_cke;
    issue(1'b0, 4'b0011, 3'd7, 15'h7fff);
    chk("R3 cke low masks activate", {26'd0, pv}, 32'd0);
    chk("R3 row unchanged", {17'd0, act_row}, 32'h5a3c);
    issue(1'b0, 4'b0000, 3'd0, 15'h0002);
    issue(1'b1, 4'b0101, 3'd0, 15'h0000);
    chk("R3 masked mode load has no effect", {31'd0, col_chop}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    put(1'b0, 4'b1111, 3'd0, 15'd0);
    @(negedge clk);
    t_reset();
    t_activate();
    t_read_write();
    t_precharge();
    t_refresh();
    t_mode_load();
    t_burst_chop();
    t_masking();
    t_cke();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule